// File: doc/BRIEF.md
# Indirect Call History Predictor

This block predicts the destination of indirect calls and indirect jumps. Unlike a plain target buffer, which keeps one destination per call site, it mixes the low address bits of the call site with a compressed image of recent control-flow history. One call site can therefore own several entries, each selected by a different path leading up to it. The front end asserts a lookup only for indirect control transfers. The block returns a hit flag and a full 64-bit target. When it misses, it raises a fallback-select line so that the caller takes the prediction from the separate generic target buffer instead.

The lookup path is combinational against a 256-entry direct-mapped table. The history register is owned by another block and is presented here as a 58-bit input. When the branch resolves, the update port presents the call site, the history that was used for the lookup, the resolved destination and what the lookup predicted. The table is written only when that prediction was absent or wrong.

Top module: `icp_predictor`

## Requirements
- R1: While `lk_valid` is low, `lk_hit` and `lk_use_generic` are both 0 and `lk_target` is 0, whatever the other lookup inputs carry.
- R2: After synchronous reset (`rst_n` low at a clock edge) every entry is empty, so each lookup misses until an update has written the entry it selects.
- R3: The 58-bit history is folded to 12 bits by XOR of its slices hist[11:0], hist[23:12], hist[35:24], hist[47:36] and hist[57:48] (the last one zero-extended). The key is fold XOR src[11:0]. The entry index is key[7:0], and the stored tag is {key[11:8], fold} (16 bits). A lookup hits only if the indexed entry is valid and its tag equals the lookup's tag. Two histories with the same fold are therefore indistinguishable.
- R4: One call site can hold distinct targets under histories whose keys differ, and each history returns its own target.
- R5: On a hit, `lk_target` is the full 64-bit target that was last written into that entry. On a miss, `lk_target` is 0.
- R6: `lk_use_generic` is high exactly when `lk_valid` is high and the lookup misses.
- R7: An update with `upd_valid` high and `upd_pred_hit` low writes the entry selected by the update's source and history with the update's tag and target.
- R8: An update with `upd_pred_hit` high and `upd_target` different from `upd_pred_target` overwrites the selected entry with the new tag and target.
- R9: An update with `upd_pred_hit` high and `upd_target` equal to `upd_pred_target` leaves the table unchanged, even if the selected entry holds a different tag.
- R10: A write made at a clock edge is seen by lookups from that edge on. A lookup presented in the same cycle as an update sees the contents from before the write.
- R11: The table is direct mapped. A write to an index replaces whichever tag was there before, so the former occupant then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request for an indirect call or jump |
| lk_src_lo | input | 12 | Low 12 bits of the call-site address |
| lk_hist | input | 58 | Global branch history at lookup |
| lk_hit | output | 1 | Matching entry found |
| lk_target | output | 64 | Predicted target (0 on miss) |
| lk_use_generic | output | 1 | Take the generic target buffer's prediction |
| upd_valid | input | 1 | Resolved indirect branch update |
| upd_src_lo | input | 12 | Low 12 bits of the resolved call site |
| upd_hist | input | 58 | History that was used for the lookup |
| upd_target | input | 64 | Resolved target |
| upd_pred_hit | input | 1 | Whether that lookup hit |
| upd_pred_target | input | 64 | Target that lookup predicted |

## Verification
The bench fills every one of the 256 indices and reads each back. This exposes an index built from the wrong key bits, because two call sites would then share an entry and one would return the other's target. It places history bits only in the short top slice, and uses histories whose slices cancel. A fold that drops the top slice, or fails to XOR the slices, shows up as a false miss or a false hit. It sends a suppressed update that aims at an index occupied by a different tag. A design that writes on a correct prediction would evict that entry, and a later lookup of it would miss. It also checks a lookup issued in the same cycle as a write. A table that forwards the write, or delays it by one cycle, would report the wrong hit state in that cycle or in the next one.

// File: rtl/icp_pkg.sv
// Package: shared types for the indirect call history predictor.
// Assumes nothing beyond IEEE 1800-2017.
package icp_pkg;
    // Reason an update commits to the table.
    typedef enum logic [1:0] {
        WR_NONE    = 2'd0,
        WR_FILL    = 2'd1,
        WR_CORRECT = 2'd2
    } wr_cause_e;
endpackage

// File: rtl/icp_hash.sv
// Module: icp_hash
// Folds a global history vector into KEY_W bits by XOR of its KEY_W-wide
// slices (the top slice zero-extended). It XORs the fold with the call-site
// low bits to form a key, then splits the key into a table index and a tag.
// The tag carries the high key bits plus the whole fold.
// Assumes IDX_W < KEY_W.
module icp_hash #(
    parameter int HIST_W = 58,
    parameter int KEY_W  = 12,
    parameter int IDX_W  = 8,
    localparam int TAG_W = (KEY_W - IDX_W) + KEY_W
) (
    input  logic [KEY_W-1:0]  src_lo,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int SLICES = (HIST_W + KEY_W - 1) / KEY_W;
    localparam int PAD_W  = SLICES * KEY_W;

    logic [PAD_W-1:0] hist_pad;
    logic [KEY_W-1:0] chain [SLICES+1];
    logic [KEY_W-1:0] fold;
    logic [KEY_W-1:0] key;

    // Zero-extend history to a whole number of slices.
    assign hist_pad = PAD_W'(hist);
    assign chain[0] = '0;

    // XOR chain across the history slices.
    for (genvar s = 0; s < SLICES; s++) begin : g_fold
        assign chain[s+1] = chain[s] ^ hist_pad[s*KEY_W +: KEY_W];
    end

    // Key, index and tag formation.
    always_comb begin
        fold = chain[SLICES];
        key  = fold ^ src_lo;
        idx  = key[IDX_W-1:0];
        tag  = {key[KEY_W-1:IDX_W], fold};
    end
endmodule

// File: rtl/icp_table.sv
// Module: icp_table
// Direct-mapped storage of (valid, tag, target). The read is combinational
// and returns the contents from before any write at the coming edge. The
// write is synchronous. Reset clears only the valid bits.
// Assumes at most one write per cycle.
module icp_table #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 16,
    parameter int TGT_W = 64,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [TGT_W-1:0] rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_target
);
    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [TGT_W-1:0] tgt_q [DEPTH];

    // Valid bits: cleared on reset, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and target payload, written without reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    // Combinational tag compare and target read.
    always_comb begin
        rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_target = rd_hit ? tgt_q[rd_idx] : '0;
    end

    // R10: a committed write is resident at the next edge
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
                   && tgt_q[$past(wr_idx)] == $past(wr_target)));
endmodule

// File: rtl/icp_predictor.sv
// Module: icp_predictor (top)
// Indirect-call target predictor keyed by call-site low bits and folded
// global history. On a lookup miss it selects the generic target buffer.
// Updates write only on a miss or a wrong target.
// Assumes the history input is owned and advanced by another block.
module icp_predictor #(
    parameter int SRC_W  = 12,
    parameter int HIST_W = 58,
    parameter int IDX_W  = 8,
    parameter int TGT_W  = 64,
    localparam int TAG_W = (SRC_W - IDX_W) + SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [SRC_W-1:0]  lk_src_lo,
    input  logic [HIST_W-1:0] lk_hist,
    output logic              lk_hit,
    output logic [TGT_W-1:0]  lk_target,
    output logic              lk_use_generic,
    input  logic              upd_valid,
    input  logic [SRC_W-1:0]  upd_src_lo,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic [TGT_W-1:0]  upd_target,
    input  logic              upd_pred_hit,
    input  logic [TGT_W-1:0]  upd_pred_target
);
    import icp_pkg::*;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             tbl_hit;
    logic [TGT_W-1:0] tbl_target;
    wr_cause_e        wr_cause;
    logic             wr_en;

    icp_hash #(.HIST_W(HIST_W), .KEY_W(SRC_W), .IDX_W(IDX_W)) i_lk_hash (
        .src_lo(lk_src_lo), .hist(lk_hist), .idx(lk_idx), .tag(lk_tag)
    );

    icp_hash #(.HIST_W(HIST_W), .KEY_W(SRC_W), .IDX_W(IDX_W)) i_up_hash (
        .src_lo(upd_src_lo), .hist(upd_hist), .idx(up_idx), .tag(up_tag)
    );

    icp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) i_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_tag(lk_tag),
        .rd_hit(tbl_hit), .rd_target(tbl_target),
        .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_target(upd_target)
    );

    // Classify an update: fill on a miss, correct on a wrong target.
    always_comb begin
        if (!upd_valid)                       wr_cause = WR_NONE;
        else if (!upd_pred_hit)               wr_cause = WR_FILL;
        else if (upd_target != upd_pred_target) wr_cause = WR_CORRECT;
        else                                  wr_cause = WR_NONE;
        wr_en = (wr_cause != WR_NONE);
    end

    // Qualify the table result with the lookup request.
    always_comb begin
        lk_hit         = lk_valid && tbl_hit;
        lk_target      = lk_hit ? tbl_target : '0;
        lk_use_generic = lk_valid && !tbl_hit;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_use_generic && lk_target == '0));

    // R6
    fallback_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_use_generic));

    // R2
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit);

    // R5: a repeated lookup with no write in between returns the same answer
    repeat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(lk_valid) && $past(rst_n) && !$past(upd_valid)
         && $stable(lk_src_lo) && $stable(lk_hist))
        |-> ($stable(lk_hit) && $stable(lk_target)));
endmodule

// File: tb/test_icp_predictor.sv
// Bench for icp_predictor: a reference table computed from the requirements,
// a sweep over every index, and directed fold, eviction and update cases.
module test_icp_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [11:0] lk_src_lo = '0;
    logic [57:0] lk_hist = '0;
    logic        lk_hit;
    logic [63:0] lk_target;
    logic        lk_use_generic;
    logic        upd_valid = 1'b0;
    logic [11:0] upd_src_lo = '0;
    logic [57:0] upd_hist = '0;
    logic [63:0] upd_target = '0;
    logic        upd_pred_hit = 1'b0;
    logic [63:0] upd_pred_target = '0;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic        m_v   [256];
    logic [15:0] m_tag [256];
    logic [63:0] m_tgt [256];

    always #2 clk = ~clk;

    icp_predictor i_icp_predictor (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_src_lo(lk_src_lo), .lk_hist(lk_hist),
        .lk_hit(lk_hit), .lk_target(lk_target), .lk_use_generic(lk_use_generic),
        .upd_valid(upd_valid), .upd_src_lo(upd_src_lo), .upd_hist(upd_hist),
        .upd_target(upd_target), .upd_pred_hit(upd_pred_hit),
        .upd_pred_target(upd_pred_target)
    );

    function automatic logic [11:0] fold_of(input logic [57:0] h);
        logic [59:0] p = {2'b00, h};
        logic [11:0] f = '0;
        for (int s = 0; s < 5; s++) f ^= p[s*12 +: 12];
        return f;
    endfunction

    function automatic logic [7:0] idx_of(input logic [11:0] s, input logic [57:0] h);
        logic [11:0] k = fold_of(h) ^ s;
        return k[7:0];
    endfunction

    function automatic logic [15:0] tag_of(input logic [11:0] s, input logic [57:0] h);
        logic [11:0] k = fold_of(h) ^ s;
        return {k[11:8], fold_of(h)};
    endfunction

    task automatic chk(input string req, input logic v, input logic [11:0] s,
                       input logic [57:0] h);
        logic [7:0]  i  = idx_of(s, h);
        logic        eh = v && m_v[i] && (m_tag[i] == tag_of(s, h));
        logic [63:0] et = eh ? m_tgt[i] : 64'd0;
        logic        eg = v && !eh;
        n_vec++;
        if (lk_hit !== eh || lk_target !== et || lk_use_generic !== eg) begin
            n_bad++;
            $display("FAIL %s src=%h hist=%h: hit/gen/tgt act %b/%b/%h exp %b/%b/%h",
                     req, s, h, lk_hit, lk_use_generic, lk_target, eh, eg, et);
        end
    endtask

    task automatic look(input string req, input logic v, input logic [11:0] s,
                        input logic [57:0] h);
        @(negedge clk);
        lk_valid = v; lk_src_lo = s; lk_hist = h;
        #1;
        chk(req, v, s, h);
    endtask

    task automatic model_write(input logic [11:0] s, input logic [57:0] h,
                               input logic [63:0] t, input logic ph, input logic [63:0] pt);
        if (!ph || t != pt) begin
            m_v[idx_of(s, h)]   = 1'b1;
            m_tag[idx_of(s, h)] = tag_of(s, h);
            m_tgt[idx_of(s, h)] = t;
        end
    endtask

    task automatic upd(input logic [11:0] s, input logic [57:0] h, input logic [63:0] t,
                       input logic ph, input logic [63:0] pt);
        @(negedge clk);
        lk_valid = 1'b0;
        upd_valid = 1'b1; upd_src_lo = s; upd_hist = h;
        upd_target = t; upd_pred_hit = ph; upd_pred_target = pt;
        @(posedge clk);
        model_write(s, h, t, ph, pt);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2, R6: empty after reset, fallback selected
        look("R2", 1'b1, 12'h123, 58'h0);
        look("R6", 1'b1, 12'hFFF, {58{1'b1}});
        // R1: idle lookup is quiet
        look("R1", 1'b0, 12'h123, 58'h0);

        // R7, R5: sweep every index with a miss-fill, read each back
        for (int i = 0; i < 256; i++)
            upd(12'(i), 58'h0, {32'hC0DE_0000 | 32'(i), 32'hF00D_0000 ^ 32'(i * 7)}, 1'b0, 64'd0);
        for (int i = 0; i < 256; i++) look("R7", 1'b1, 12'(i), 58'h0);
        // R1 again with a trained address
        look("R1", 1'b0, 12'h010, 58'h0);
        // R3: high source nibble changes the tag only, so a miss
        look("R3", 1'b1, 12'h310, 58'h0);
        // R3: equal slices cancel in the fold, so a hit on the hist-0 entry
        look("R3", 1'b1, 12'h022, {34'h0, 12'h5A5, 12'h5A5});
        // R3: bits only in the short top slice move the key: src 0x005 -> index 6, fold 3 -> miss
        look("R3", 1'b1, 12'h005, 58'h3 << 48);

        // R4: same site, second history, second target
        upd(12'h005, 58'h3 << 48, 64'hDEAD_BEEF_0000_0006, 1'b0, 64'd0);
        look("R4", 1'b1, 12'h005, 58'h3 << 48);
        look("R4", 1'b1, 12'h005, 58'h0);
        // R11: index 6 was taken over; the old occupant (src 6, hist 0) misses
        look("R11", 1'b1, 12'h006, 58'h0);

        // R9: suppressed update aimed at occupied index 0x40 with another tag
        upd(12'h140, 58'h0, 64'h1111, 1'b1, 64'h1111);
        look("R9", 1'b1, 12'h040, 58'h0);
        look("R9", 1'b1, 12'h140, 58'h0);

        // R8: predicted hit with wrong target replaces the target
        upd(12'h041, 58'h0, 64'h7777_6666_5555_4444, 1'b1, 64'h1);
        look("R8", 1'b1, 12'h041, 58'h0);

        // R10: lookup in the update cycle sees old contents, then new
        @(negedge clk);
        upd_valid = 1'b1; upd_src_lo = 12'h0A0; upd_hist = 58'h0123_4567;
        upd_target = 64'h0BAD_F00D_0000_00A0; upd_pred_hit = 1'b0; upd_pred_target = '0;
        lk_valid = 1'b1; lk_src_lo = 12'h0A0; lk_hist = 58'h0123_4567;
        #1;
        chk("R10", 1'b1, 12'h0A0, 58'h0123_4567);
        @(posedge clk);
        model_write(12'h0A0, 58'h0123_4567, 64'h0BAD_F00D_0000_00A0, 1'b0, 64'd0);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        chk("R10", 1'b1, 12'h0A0, 58'h0123_4567);

        // R2: reset empties a trained table
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 256; i++) m_v[i] = 1'b0;
        look("R2", 1'b1, 12'h041, 58'h0);
        look("R2", 1'b1, 12'h005, 58'h3 << 48);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule